// File: doc/BRIEF.md
# Queue Event Interrupt Selector

This block turns the status nibbles of a bank of hardware queues into one interrupt line. Every queue reports four level flags: empty, nearly empty, nearly full and full. Software gives each queue a 3-bit event code. The code picks one of the four flags and can invert it, which gives eight possible conditions per queue. When the chosen condition goes from false to true on a queue that is enabled, a sticky request bit is latched for that queue. The interrupt output is high whenever any request bit is set.

Software reaches the block through a simple single-cycle register bus. Writes take effect on the clock edge on which `reg_wr` is sampled high. Read data is combinational from the current register state. Event codes sit in 4-bit lanes, eight queues per word. One word holds the per-queue enables. Another word holds the requests, and each of its bits is cleared by writing a one. Software finds the cause of an interrupt by reading the request word. It acknowledges the interrupt by writing those bits back.

Top module: `qirq_top`

## Requirements
- R1: After reset every event code, every enable bit and every request bit is zero, and `irq` is low.
- R2: Word addresses 0 to 3 hold event codes. Queue q uses word q/8, and its code sits in bits [4*(q mod 8)+2 : 4*(q mod 8)]. Bit 4*(q mod 8)+3 is reserved: writes to it are dropped and it always reads back as zero.
- R3: The condition of a queue is status bit s of its nibble, XORed with code bit 2, where s is code bits [1:0]. The nibble bits are 0 = empty, 1 = nearly empty, 2 = nearly full and 3 = full. This gives codes 0 to 3 = empty, nearly empty, nearly full, full, and codes 4 to 7 = the negation of each.
- R4: A false-to-true change of a queue's condition sets that queue's request bit, provided the queue is enabled. The bit is visible in the request word after the first rising clock edge on which the new condition is sampled.
- R5: A queue that is disabled never latches a request. Enabling a queue while its condition is already true does not latch a request, because only a change counts.
- R6: Word address 5 is the request word, bit q for queue q. Writing a one to a bit clears it. Writing a zero leaves it unchanged. Writing all ones clears every request.
- R7: Word address 4 is the enable word, bit q for queue q, and it reads back what was written. A write that leaves an enable bit at zero also clears that queue's request bit on the same edge.
- R8: `irq` is high exactly when the request word is non-zero, in the same cycle.
- R9: If a condition change and a write-one-to-clear of the same bit fall on the same edge, the new request wins and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe, sampled on the rising clock edge |
| reg_addr | input | 3 | Word address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| q_status | input | 128 | Status nibble per queue, queue q at bits [4q+3:4q] |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench drives inputs just after a falling edge. A register write or a status change then reaches the request word after exactly one rising edge, so the bench reads at the next falling edge. A change of event code takes two edges to show as a request: the code register updates on the first edge and the condition is latched on the second. The bench waits one more falling edge in that case. Read data and `irq` are combinational from the flops, so they are sampled 1 ns after a falling edge with the write strobe low.

// File: rtl/qirq_pkg.sv
package qirq_pkg;

    localparam int unsigned FLAG_W = 4;
    localparam int unsigned CODE_W = 3;
    localparam int unsigned LANE_W = 4;

    typedef enum logic [1:0] {
        FLG_EMPTY  = 2'd0,
        FLG_NEMPTY = 2'd1,
        FLG_NFULL  = 2'd2,
        FLG_FULL   = 2'd3
    } flag_idx_e;

    typedef struct packed {
        logic      invert;
        flag_idx_e flag;
    } src_code_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_SEL,
        ACC_EN,
        ACC_REQ
    } reg_kind_e;

    function automatic logic eval_cond(input src_code_t c, input logic [FLAG_W-1:0] st);
        return st[c.flag] ^ c.invert;
    endfunction

    function automatic reg_kind_e decode_kind(input int unsigned a, input int unsigned nsel);
        if (a < nsel)          return ACC_SEL;
        else if (a == nsel)    return ACC_EN;
        else if (a == nsel + 1) return ACC_REQ;
        else                   return ACC_NONE;
    endfunction

endpackage

// File: rtl/qirq_cfg.sv
module qirq_cfg import qirq_pkg::*; #(
    parameter int unsigned NQ = 32,
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 3
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_sel,
    input  logic                 wr_en,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    output src_code_t [NQ-1:0]   sel_o,
    output logic [NQ-1:0]        en_o,
    output logic [NQ-1:0]        en_keep_o
);
    localparam int unsigned LPR = DW / LANE_W;

    logic [NQ-1:0] en_q;

    for (genvar q = 0; q < NQ; q++) begin : g_code
        localparam int unsigned WORD = q / LPR;
        localparam int unsigned LANE = q % LPR;
        src_code_t code_q;

        always_ff @(posedge clk) begin
            if (rst)
                code_q <= '0;
            else if (wr_sel && addr == AW'(WORD))
                code_q <= src_code_t'(wdata[LANE*LANE_W +: CODE_W]);
        end

        assign sel_o[q] = code_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (wr_en)
            en_q <= wdata[NQ-1:0];
    end

    assign en_o      = en_q;
    // enable value in force after this edge: gates retention of requests
    assign en_keep_o = wr_en ? wdata[NQ-1:0] : en_q;

endmodule

// File: rtl/qirq_edge.sv
module qirq_edge import qirq_pkg::*; #(
    parameter int unsigned NQ = 32
)(
    input  logic                  clk,
    input  logic                  rst,
    input  src_code_t [NQ-1:0]    sel_i,
    input  logic [NQ*FLAG_W-1:0]  stat_i,
    output logic [NQ-1:0]         cond_o,
    output logic [NQ-1:0]         rise_o
);
    logic [NQ-1:0] cond_d;

    for (genvar q = 0; q < NQ; q++) begin : g_cond
        assign cond_o[q] = eval_cond(sel_i[q], stat_i[q*FLAG_W +: FLAG_W]);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cond_d <= '0;
        else
            cond_d <= cond_o;
    end

    assign rise_o = cond_o & ~cond_d;

endmodule

// File: rtl/qirq_pend.sv
module qirq_pend #(
    parameter int unsigned NQ = 32
)(
    input  logic          clk,
    input  logic          rst,
    input  logic [NQ-1:0] rise_i,
    input  logic [NQ-1:0] en_i,
    input  logic [NQ-1:0] keep_i,
    input  logic [NQ-1:0] clr_i,
    output logic [NQ-1:0] req_o,
    output logic          irq_o
);
    logic [NQ-1:0] req_q;
    logic [NQ-1:0] req_n;

    always_comb begin
        // new events override a same-cycle clear; disabling drops everything
        req_n = ((req_q & ~clr_i) | (rise_i & en_i)) & keep_i;
    end

    always_ff @(posedge clk) begin
        if (rst)
            req_q <= '0;
        else
            req_q <= req_n;
    end

    assign req_o = req_q;
    assign irq_o = |req_q;

endmodule

// File: rtl/qirq_top.sv
module qirq_top import qirq_pkg::*; #(
    parameter int unsigned NQ = 32,
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 3
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [AW-1:0]        reg_addr,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    input  logic [NQ*FLAG_W-1:0] q_status,
    output logic                 irq
);
    localparam int unsigned LPR  = DW / LANE_W;
    localparam int unsigned NSEL = (NQ + LPR - 1) / LPR;

    reg_kind_e          kind;
    src_code_t [NQ-1:0] sel;
    logic [NQ-1:0]      en;
    logic [NQ-1:0]      en_keep;
    logic [NQ-1:0]      cond;
    logic [NQ-1:0]      rise;
    logic [NQ-1:0]      req;
    logic [NQ-1:0]      clr;
    logic [NSEL-1:0][DW-1:0] sel_word;

    assign kind = decode_kind(32'(reg_addr), NSEL);
    assign clr  = (reg_wr && kind == ACC_REQ) ? reg_wdata[NQ-1:0] : '0;

    qirq_cfg #(.NQ(NQ), .DW(DW), .AW(AW)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_sel    (reg_wr && kind == ACC_SEL),
        .wr_en     (reg_wr && kind == ACC_EN),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .sel_o     (sel),
        .en_o      (en),
        .en_keep_o (en_keep)
    );

    qirq_edge #(.NQ(NQ)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .sel_i  (sel),
        .stat_i (q_status),
        .cond_o (cond),
        .rise_o (rise)
    );

    qirq_pend #(.NQ(NQ)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .rise_i (rise),
        .en_i   (en),
        .keep_i (en_keep),
        .clr_i  (clr),
        .req_o  (req),
        .irq_o  (irq)
    );

    for (genvar w = 0; w < NSEL; w++) begin : g_word
        for (genvar l = 0; l < LPR; l++) begin : g_lane
            if (w*LPR + l < NQ) begin : g_used
                assign sel_word[w][l*LANE_W +: CODE_W] = sel[w*LPR + l];
                assign sel_word[w][l*LANE_W + CODE_W]  = 1'b0;
            end else begin : g_pad
                assign sel_word[w][l*LANE_W +: LANE_W] = '0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (kind)
            ACC_SEL: begin
                for (int w = 0; w < int'(NSEL); w++)
                    if (reg_addr == AW'(w)) reg_rdata = sel_word[w];
            end
            ACC_EN:  reg_rdata[NQ-1:0] = en;
            ACC_REQ: reg_rdata[NQ-1:0] = req;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/qirq_chk.sv
module qirq_chk #(
    parameter int unsigned NQ = 32,
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 3
)(
    input logic          clk,
    input logic          rst,
    input logic          reg_wr,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] reg_rdata,
    input logic          irq,
    input logic [NQ-1:0] req,
    input logic [NQ-1:0] en,
    input logic [NQ-1:0] cond
);
    localparam int unsigned LPR  = DW / 4;
    localparam int unsigned NSEL = (NQ + LPR - 1) / LPR;
    localparam logic [AW-1:0] A_EN  = AW'(NSEL);
    localparam logic [AW-1:0] A_REQ = AW'(NSEL + 1);

    function automatic logic [DW-1:0] rsv_mask();
        logic [DW-1:0] m = '0;
        for (int l = 0; l < int'(LPR); l++) m[l*4 + 3] = 1'b1;
        return m;
    endfunction
    localparam logic [DW-1:0] RSV = rsv_mask();

    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (req == '0 && en == '0 && !irq));

    // R2
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr && 32'(reg_addr) < NSEL) |-> ((reg_rdata & RSV) == '0));

    // R4
    newreq_cond_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((req & ~$past(req) & ~$past(cond)) == '0));

    // R5
    newreq_en_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((req & ~$past(req) & ~$past(en)) == '0));

    // R7
    dis_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_EN) |=> ((req & ~$past(reg_wdata[NQ-1:0])) == '0));

    // R7
    en_load_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_EN) |=> (en == $past(reg_wdata[NQ-1:0])));

    // R8
    irq_view_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == A_REQ) |-> (irq == (reg_rdata != '0)));

endmodule

bind qirq_top qirq_chk #(.NQ(NQ), .DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .req       (req),
    .en        (en),
    .cond      (cond)
);

// File: tb/tb_qirq_top.sv
`timescale 1ns/1ps
module tb_qirq_top;
    localparam int NQ = 32;
    localparam int DW = 32;
    localparam int AW = 3;
    localparam logic [AW-1:0] A_EN  = 3'd4;
    localparam logic [AW-1:0] A_REQ = 3'd5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic [AW-1:0]     reg_addr = '0;
    logic [DW-1:0]     reg_wdata = '0;
    logic [DW-1:0]     reg_rdata;
    logic [NQ*4-1:0]   q_status = '0;
    logic              irq;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    qirq_top #(.NQ(NQ), .DW(DW), .AW(AW)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .q_status(q_status), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic model(input logic [2:0] c, input logic [3:0] n);
        return n[c[1:0]] ^ c[2];
    endfunction

    function automatic logic [NQ*4-1:0] all_nib(input logic [3:0] n);
        logic [NQ*4-1:0] v;
        for (int q = 0; q < NQ; q++) v[q*4 +: 4] = n;
        return v;
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        logic [DW-1:0] pat;
        logic [3:0]    base;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(AW'(a), d);
            check("R1 reset word", d, 32'h0);
        end
        check("R1 irq low", {31'b0, irq}, 32'h0);

        // R7 enable readback
        wr(A_EN, 32'hA5C3_0F12);
        rd(A_EN, d);
        check("R7 enable readback", d, 32'hA5C3_0F12);
        wr(A_EN, 32'h0);

        // R2 code words and reserved bits
        for (int a = 0; a < 4; a++) begin
            wr(AW'(a), 32'hFFFF_FFFF);
            rd(AW'(a), d);
            check("R2 reserved bits read zero", d, 32'h7777_7777);
            pat = 32'h89AB_CDEF + 32'(a) * 32'h0123_4567;
            wr(AW'(a), pat);
            rd(AW'(a), d);
            check("R2 code readback", d, pat & 32'h7777_7777);
            wr(AW'(a), 32'h0);
        end

        // R2 R4 lane placement: code 4 on idle queue makes a rising condition
        wr(A_EN, 32'hFFFF_FFFF);
        for (int q = 0; q < NQ; q++) begin
            wr(AW'(q / 8), 32'h4 << ((q % 8) * 4));
            @(negedge clk);
            rd(A_REQ, d);
            check("R2 lane maps to queue", d, 32'h1 << q);
            check("R8 irq with one request", {31'b0, irq}, 32'h1);
            wr(AW'(q / 8), 32'h0);
            wr(A_REQ, 32'hFFFF_FFFF);
            rd(A_REQ, d);
            check("R6 clear after lane test", d, 32'h0);
        end

        // R6 write-one-to-clear
        @(negedge clk); q_status = all_nib(4'h1);
        @(negedge clk);
        rd(A_REQ, d);
        check("R4 all queues latch", d, 32'hFFFF_FFFF);
        wr(A_REQ, 32'h0000_00F0);
        rd(A_REQ, d);
        check("R6 partial clear", d, 32'hFFFF_FF0F);
        wr(A_REQ, 32'h0);
        rd(A_REQ, d);
        check("R6 zero write no effect", d, 32'hFFFF_FF0F);
        wr(A_REQ, 32'hFFFF_FFFF);
        rd(A_REQ, d);
        check("R6 all ones clears", d, 32'h0);
        check("R8 irq low after clear", {31'b0, irq}, 32'h0);

        // R7 disable clears pending
        @(negedge clk); q_status = '0;
        @(negedge clk); q_status = all_nib(4'h1);
        @(negedge clk);
        wr(A_EN, 32'hFFFF_0000);
        rd(A_REQ, d);
        check("R7 disable drops requests", d, 32'hFFFF_0000);
        rd(A_EN, d);
        check("R7 enable word", d, 32'hFFFF_0000);

        // R5 disabled queues never latch
        wr(A_REQ, 32'hFFFF_FFFF);
        @(negedge clk); q_status = '0;
        @(negedge clk); q_status = all_nib(4'h1);
        @(negedge clk);
        rd(A_REQ, d);
        check("R5 only enabled queues latch", d, 32'hFFFF_0000);

        // R5 enabling with condition already true
        wr(A_REQ, 32'hFFFF_FFFF);
        wr(A_EN, 32'hFFFF_FFFF);
        repeat (2) @(negedge clk);
        rd(A_REQ, d);
        check("R5 level at enable ignored", d, 32'h0);
        check("R8 irq stays low", {31'b0, irq}, 32'h0);

        // R9 event beats same-edge clear
        @(negedge clk); q_status = '0;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_REQ; reg_wdata = 32'h1;
        q_status[3:0] = 4'h1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        rd(A_REQ, d);
        check("R9 set wins over clear", d, 32'h1);

        // R3 sweep of every code against every nibble on queue 5
        q_status = '0;
        for (int c = 0; c < 8; c++) begin
            for (int n = 0; n < 16; n++) begin
                wr(A_EN, 32'h0);
                base = c[2] ? 4'hF : 4'h0;
                q_status[5*4 +: 4] = base;
                wr(3'd0, 32'(c) << 20);
                wr(A_EN, 32'h1 << 5);
                q_status[5*4 +: 4] = 4'(n);
                @(negedge clk);
                rd(A_REQ, d);
                check($sformatf("R3 code %0d nibble %h", c, n), d,
                      model(3'(c), 4'(n)) ? 32'h20 : 32'h0);
                check("R8 irq follows sweep", {31'b0, irq},
                      {31'b0, model(3'(c), 4'(n))});
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule